// File: doc/BRIEF.md
# Non-Intrusive Line Monitor Selector

This block lets the first channel of an eight-channel line interface serve as a monitor port. A 4-bit control word names one of the other seven channels and chooses whether its receive signal or its transmit signal is tapped. The tapped clock and its positive and negative data are copied onto the monitor channel's receive outputs. The monitored channel keeps running untouched. When the control word selects no source, the monitor channel works as an ordinary channel.

All channels' digital receive outputs pass through this block on one register stage clocked by the monitor clock. The block also drives the monitor channel's transmit line data. In remote loopback, that transmit data is whatever the monitor channel's receive path carries, so a tapped signal can be sent out on the line. Otherwise the monitor channel transmits its own data. Channel n of the interface is bit n-1 of every per-channel vector.

Top module: `line_monitor_select`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: The receive outputs of channels 2 to 8 (bits 7:1) equal their own receive inputs one clock earlier, whatever the control word or loopback setting. Monitoring never alters a tapped channel.
- R3: When `mon_ctrl[2:0]` is 000, monitoring is off whatever bit 3 holds. Channel 1's receive outputs then equal its own receive inputs one clock earlier.
- R4: When `mon_ctrl[3]` is 0 and `mon_ctrl[2:0]` = k (1 to 7), channel 1's receive clock, positive and negative data outputs equal the receive clock, positive and negative inputs of bit k one clock earlier.
- R5: When `mon_ctrl[3]` is 1 and `mon_ctrl[2:0]` = k (1 to 7), channel 1's receive outputs equal the transmit clock, positive and negative inputs of bit k one clock earlier.
- R6: When `remote_loop` is 0, the transmit line outputs equal channel 1's own transmit positive and negative inputs one clock earlier.
- R7: When `remote_loop` is 1, the transmit line outputs equal the positive and negative data placed on channel 1's receive outputs in the same cycle. This is the tapped data while monitoring and channel 1's own receive data otherwise.
- R8: Every output is registered. A change of `mon_ctrl` or `remote_loop` first shows on the outputs after the next rising clock edge, and the outputs hold until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_ctrl | input | 4 | Bit 3 direction (1 transmit, 0 receive), bits 2:0 source channel code |
| remote_loop | input | 1 | Remote loopback of the monitor channel |
| rx_clk_i | input | 8 | Recovered receive clock per channel |
| rx_pos_i | input | 8 | Receive positive data per channel |
| rx_neg_i | input | 8 | Receive negative data per channel |
| tx_clk_i | input | 8 | Transmit clock per channel |
| tx_pos_i | input | 8 | Transmit positive data per channel |
| tx_neg_i | input | 8 | Transmit negative data per channel |
| rx_clk_o | output | 8 | Registered receive clock per channel |
| rx_pos_o | output | 8 | Registered receive positive data per channel |
| rx_neg_o | output | 8 | Registered receive negative data per channel |
| line_tx_pos_o | output | 1 | Monitor channel transmit line positive data |
| line_tx_neg_o | output | 1 | Monitor channel transmit line negative data |

## Verification
The bench walks every source code in both directions. It gives each channel a distinct pattern, so a decoder off by one channel, or one that swaps the receive and transmit taps, shows up as a wrong bit on channel 1. Code 1000 is driven on its own, because a design that decoded only bit 3 would start tapping a nonexistent source. Loopback is exercised both with and without monitoring: a design that looped only its own data, or that leaked the tap onto the transmit line without loopback, fails one of the two. A control change is checked just before and just after the clock edge to catch a combinational path or an extra register stage.

// File: rtl/lmon_pkg.sv
package lmon_pkg;

  localparam int SRC_W  = 3;
  localparam int CTRL_W = SRC_W + 1;

  typedef struct packed {
    logic             en;
    logic             tx_dir;
    logic [SRC_W-1:0] src;
  } mon_sel_t;

  typedef struct packed {
    logic clk;
    logic p;
    logic n;
  } tap_t;

  // Source code zero means no monitoring, independent of direction bit.
  function automatic mon_sel_t decode_ctrl(input logic [CTRL_W-1:0] code);
    mon_sel_t s;
    s.src    = code[SRC_W-1:0];
    s.tx_dir = code[CTRL_W-1];
    s.en     = |code[SRC_W-1:0];
    return s;
  endfunction

endpackage

// File: rtl/lmon_tap_mux.sv
module lmon_tap_mux
  import lmon_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  mon_sel_t          sel,
  input  logic [NUM_CH-1:0] rx_clk_i,
  input  logic [NUM_CH-1:0] rx_pos_i,
  input  logic [NUM_CH-1:0] rx_neg_i,
  input  logic [NUM_CH-1:0] tx_clk_i,
  input  logic [NUM_CH-1:0] tx_pos_i,
  input  logic [NUM_CH-1:0] tx_neg_i,
  output tap_t              tap_o
);

  tap_t rx_tap [NUM_CH];
  tap_t tx_tap [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign rx_tap[i] = '{clk: rx_clk_i[i], p: rx_pos_i[i], n: rx_neg_i[i]};
    assign tx_tap[i] = '{clk: tx_clk_i[i], p: tx_pos_i[i], n: tx_neg_i[i]};
  end

  always_comb begin
    if (sel.tx_dir) tap_o = tx_tap[sel.src];
    else            tap_o = rx_tap[sel.src];
  end

endmodule

// File: rtl/lmon_port_drive.sv
module lmon_port_drive
  import lmon_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mon_sel_t          sel,
  input  tap_t              tap_i,
  input  logic              remote_loop,
  input  logic [NUM_CH-1:0] rx_clk_i,
  input  logic [NUM_CH-1:0] rx_pos_i,
  input  logic [NUM_CH-1:0] rx_neg_i,
  input  logic              tx_pos0_i,
  input  logic              tx_neg0_i,
  output logic [NUM_CH-1:0] rx_clk_o,
  output logic [NUM_CH-1:0] rx_pos_o,
  output logic [NUM_CH-1:0] rx_neg_o,
  output logic              line_tx_pos_o,
  output logic              line_tx_neg_o
);

  localparam int OTH = NUM_CH - 1;

  // Named internal events for the assertions.
  logic mon_active;
  tap_t own_rx;
  tap_t ch1_next;
  logic loop_path;
  logic armed;

  assign mon_active = sel.en;
  assign own_rx     = '{clk: rx_clk_i[0], p: rx_pos_i[0], n: rx_neg_i[0]};
  assign ch1_next   = mon_active ? tap_i : own_rx;
  assign loop_path  = remote_loop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_clk_o      <= '0;
      rx_pos_o      <= '0;
      rx_neg_o      <= '0;
      line_tx_pos_o <= 1'b0;
      line_tx_neg_o <= 1'b0;
      armed         <= 1'b0;
    end else begin
      rx_clk_o[NUM_CH-1:1] <= rx_clk_i[NUM_CH-1:1];
      rx_pos_o[NUM_CH-1:1] <= rx_pos_i[NUM_CH-1:1];
      rx_neg_o[NUM_CH-1:1] <= rx_neg_i[NUM_CH-1:1];
      rx_clk_o[0]          <= ch1_next.clk;
      rx_pos_o[0]          <= ch1_next.p;
      rx_neg_o[0]          <= ch1_next.n;
      line_tx_pos_o        <= loop_path ? ch1_next.p : tx_pos0_i;
      line_tx_neg_o        <= loop_path ? ch1_next.n : tx_neg0_i;
      armed                <= 1'b1;
    end
  end

  assert_other_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rx_pos_o[OTH:1] == $past(rx_pos_i[OTH:1]) &&
               rx_neg_o[OTH:1] == $past(rx_neg_i[OTH:1]) &&
               rx_clk_o[OTH:1] == $past(rx_clk_i[OTH:1])));

  assert_idle_own_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(mon_active)) |->
      (rx_pos_o[0] == $past(rx_pos_i[0]) && rx_neg_o[0] == $past(rx_neg_i[0])));

  assert_tap_reaches_ch1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mon_active)) |->
      (rx_clk_o[0] == $past(tap_i.clk) && rx_pos_o[0] == $past(tap_i.p)));

  assert_tx_own_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(loop_path)) |->
      (line_tx_pos_o == $past(tx_pos0_i) && line_tx_neg_o == $past(tx_neg0_i)));

  assert_loop_follows_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(loop_path)) |->
      (line_tx_pos_o == rx_pos_o[0] && line_tx_neg_o == rx_neg_o[0]));

endmodule

// File: rtl/line_monitor_select.sv
module line_monitor_select
  import lmon_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mon_ctrl,
  input  logic              remote_loop,
  input  logic [NUM_CH-1:0] rx_clk_i,
  input  logic [NUM_CH-1:0] rx_pos_i,
  input  logic [NUM_CH-1:0] rx_neg_i,
  input  logic [NUM_CH-1:0] tx_clk_i,
  input  logic [NUM_CH-1:0] tx_pos_i,
  input  logic [NUM_CH-1:0] tx_neg_i,
  output logic [NUM_CH-1:0] rx_clk_o,
  output logic [NUM_CH-1:0] rx_pos_o,
  output logic [NUM_CH-1:0] rx_neg_o,
  output logic              line_tx_pos_o,
  output logic              line_tx_neg_o
);

  mon_sel_t sel;
  tap_t     tap;

  assign sel = decode_ctrl(mon_ctrl);

  lmon_tap_mux #(.NUM_CH(NUM_CH)) u_mux (
    .sel      (sel),
    .rx_clk_i (rx_clk_i),
    .rx_pos_i (rx_pos_i),
    .rx_neg_i (rx_neg_i),
    .tx_clk_i (tx_clk_i),
    .tx_pos_i (tx_pos_i),
    .tx_neg_i (tx_neg_i),
    .tap_o    (tap)
  );

  lmon_port_drive #(.NUM_CH(NUM_CH)) u_drive (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel           (sel),
    .tap_i         (tap),
    .remote_loop   (remote_loop),
    .rx_clk_i      (rx_clk_i),
    .rx_pos_i      (rx_pos_i),
    .rx_neg_i      (rx_neg_i),
    .tx_pos0_i     (tx_pos_i[0]),
    .tx_neg0_i     (tx_neg_i[0]),
    .rx_clk_o      (rx_clk_o),
    .rx_pos_o      (rx_pos_o),
    .rx_neg_o      (rx_neg_o),
    .line_tx_pos_o (line_tx_pos_o),
    .line_tx_neg_o (line_tx_neg_o)
  );

endmodule

// File: tb/tb_line_monitor_select.sv
module tb_line_monitor_select;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mon_ctrl = '0;
  logic       remote_loop = 1'b0;
  logic [7:0] rx_clk_i = '0, rx_pos_i = '0, rx_neg_i = '0;
  logic [7:0] tx_clk_i = '0, tx_pos_i = '0, tx_neg_i = '0;
  logic [7:0] rx_clk_o, rx_pos_o, rx_neg_o;
  logic       line_tx_pos_o, line_tx_neg_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1d2c_3b4a;

  always #10 clk = ~clk;

  line_monitor_select dut (.*);

  function automatic logic [25:0] actual();
    return {rx_clk_o, rx_pos_o, rx_neg_o, line_tx_pos_o, line_tx_neg_o};
  endfunction

  // Expected outputs from the current stimulus, straight from the requirements.
  function automatic logic [25:0] model();
    logic [7:0] c, p, n;
    int k;
    logic lp, ln;
    c = rx_clk_i; p = rx_pos_i; n = rx_neg_i;
    k = int'(mon_ctrl[2:0]);
    if (k != 0) begin
      c[0] = mon_ctrl[3] ? tx_clk_i[k] : rx_clk_i[k];
      p[0] = mon_ctrl[3] ? tx_pos_i[k] : rx_pos_i[k];
      n[0] = mon_ctrl[3] ? tx_neg_i[k] : rx_neg_i[k];
    end
    lp = remote_loop ? p[0] : tx_pos_i[0];
    ln = remote_loop ? n[0] : tx_neg_i[0];
    return {c, p, n, lp, ln};
  endfunction

  task automatic check(input string tag, input logic [25:0] exp);
    n_cmp++;
    if (actual() !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, actual(), exp);
    end
  endtask

  task automatic scramble();
    seed = seed * 32'd1664525 + 32'd1013904223; rx_clk_i = seed[31:24]; rx_pos_i = seed[23:16];
    rx_neg_i = seed[15:8]; tx_clk_i = seed[7:0];
    seed = seed * 32'd1664525 + 32'd1013904223; tx_pos_i = seed[31:24]; tx_neg_i = seed[19:12];
  endtask

  // Drive after a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(input string tag);
    logic [25:0] e;
    e = model();
    @(negedge clk);
    check(tag, e);
  endtask

  task automatic t_reset();
    scramble(); mon_ctrl = 4'b0011; remote_loop = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", '0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle();
    mon_ctrl = 4'b0000; remote_loop = 1'b0;
    for (int i = 0; i < 6; i++) begin scramble(); step("R3 idle own rx / R2 / R6"); end
  endtask

  task automatic t_rx_monitor();
    remote_loop = 1'b0;
    for (int k = 1; k < 8; k++)
      for (int j = 0; j < 3; j++) begin
        mon_ctrl = {1'b0, 3'(k)}; scramble(); step("R4 rx tap / R2 untouched");
      end
  endtask

  task automatic t_tx_monitor();
    remote_loop = 1'b0;
    for (int k = 1; k < 8; k++)
      for (int j = 0; j < 3; j++) begin
        mon_ctrl = {1'b1, 3'(k)}; scramble(); step("R5 tx tap / R6 own tx");
      end
  endtask

  task automatic t_dir_without_source();
    mon_ctrl = 4'b1000; remote_loop = 1'b0;
    for (int i = 0; i < 4; i++) begin scramble(); step("R3 code 1000 is off"); end
  endtask

  task automatic t_loopback();
    remote_loop = 1'b1;
    for (int k = 0; k < 8; k++) begin
      mon_ctrl = {k[0], 3'(k)}; scramble(); step("R7 loop with tap");
    end
    mon_ctrl = 4'b0000;
    for (int i = 0; i < 4; i++) begin scramble(); step("R7 loop own rx"); end
    remote_loop = 1'b0;
    for (int i = 0; i < 3; i++) begin scramble(); step("R6 loop off"); end
  endtask

  task automatic t_switch();
    logic [25:0] held;
    mon_ctrl = 4'b0010; remote_loop = 1'b0; scramble(); step("R8 first setting");
    held = actual();
    mon_ctrl = 4'b1101; remote_loop = 1'b1; scramble();
    #5; check("R8 hold before edge", held);
    step("R8 after edge");
  endtask

  initial begin
    t_reset();
    t_idle();
    t_rx_monitor();
    t_tx_monitor();
    t_dir_without_source();
    t_loopback();
    t_switch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule